// File: doc/BRIEF.md
# External Bus Yield Controller

This block decides who drives a processor's external memory bus: the processor itself or an outside master. The outside master raises a request line at any time, with no relation to the processor clock. Once that request has been synchronised, the controller turns off the processor's bus and strobe drivers and raises a grant. Unless go mode is selected, it also halts the core. Dropping the request reverses all of this.

The controller also starts the processor's own external accesses. Each requester (core memory port, byte-DMA engine and so on) holds a request bit until its access is done. The controller picks one requester by fixed priority and marks the access busy until the memory timing unit reports completion. A grant never cuts into an access in flight. It takes effect in the cycle after that access completes, which can fall between two accesses of one instruction. While the bus is granted, a hung flag shows that a requester is stalled waiting for it.

The arbitration side runs from its own power-on reset. The processor's reset only holds back the processor's own accesses, so the outside master can take the bus during boot or while the core is held in reset.

Top module: `ext_bus_yield_ctrl`

## Requirements
- R1: The request input passes through a chain of SYNC_STAGES flops (default 2). A request that is steady before a clock edge gives grant high after SYNC_STAGES+1 edges and not before.
- R2: With no access in flight, grant rises one cycle after the synchronised request is seen. While grant is high and go mode is off, halt is high.
- R3: While an access is in flight and done is low, grant stays low. If the synchronised request is present, grant rises in the cycle right after the done cycle, and busy falls on that same edge.
- R4: A requester whose bit is still set after one access completes does not start a new access while the synchronised request is present. The bus is granted between the two accesses.
- R5: With go mode on, halt stays low while granted as long as no requester is pending. Halt goes high as soon as a requester bit is set.
- R6: One cycle after the synchronised request falls, grant falls, drive-enable rises and halt falls.
- R7: Hung is high exactly while grant is high and at least one unmasked requester bit is set. This includes requester 1, the byte-DMA slot.
- R8: After a release, a pending access starts (busy rises) only on the edge after grant and hung have fallen.
- R9: While core reset is high, requester bits are ignored: no access starts and hung stays low. Grant still follows the request as in R1 and R6.
- R10: Drive-enable is low in exactly the cycles in which grant is high.
- R11: After power-on reset, grant, hung, halt and busy are 0, select is all zeros and drive-enable is 1.
- R12: Requests that are set together are served lowest index first. The select output is one-hot (bit k = requester k) while busy and zero when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Power-on reset for the arbitration logic, active low |
| core_rst_i | input | 1 | Processor reset; masks requester bits while high |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master |
| go_mode_i | input | 1 | 1 = keep executing while granted until the bus is needed |
| xreq_i | input | N_REQ | Requester bits, held until the access is done; index 0 = core memory port, index 1 = byte-DMA engine |
| acc_done_i | input | 1 | High in the last cycle of the access in flight |
| grant_o | output | 1 | Bus granted to the outside master |
| hung_o | output | 1 | A requester is stalled by the grant |
| drv_en_o | output | 1 | Enables the address, data and strobe drivers |
| halt_o | output | 1 | Halts core execution |
| acc_busy_o | output | 1 | A processor external access is in flight |
| acc_sel_o | output | N_REQ | One-hot index of the requester being served |

## Verification
The assertions assume that a requester keeps its bit set until the done cycle of its own access, and that done is raised only while busy is high. The bench follows this by raising done together with clearing the served bit on one falling-edge-separated step. The outside request is changed only between clock edges and held for several cycles, so the synchroniser latency stays exact.

// File: rtl/bys_pkg.sv
package bys_pkg;
   typedef enum logic {
      OWN_CORE = 1'b0,
      OWN_EXT  = 1'b1
   } bus_owner_t;
endpackage

// File: rtl/bys_sync.sv
module bys_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("bys_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/bys_pick.sv
module bys_pick #(
   parameter int N = 2
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] pick_o
);
   logic [N:0] taken;

   assign taken[0] = 1'b0;
   generate
      for (genvar k = 0; k < N; k++) begin : g_pri
         assign pick_o[k]   = req_i[k] & ~taken[k];
         assign taken[k+1]  = taken[k] | req_i[k];
      end
   endgenerate

   always_comb begin
      assert ($countones(pick_o) <= 1)
         else $error("p_pick_onehot_r12: more than one requester picked");
   end
endmodule

// File: rtl/bys_owner.sv
module bys_owner
   import bys_pkg::*;
#(
   parameter int N_REQ = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_s_i,
   input  logic [N_REQ-1:0] xreq_i,
   input  logic             acc_done_i,
   output logic             grant_q_o,
   output logic             grant_nx_o,
   output logic             busy_o,
   output logic [N_REQ-1:0] sel_o
);
   bus_owner_t       own_q, own_nx;
   logic             busy_q, busy_nx;
   logic [N_REQ-1:0] sel_q, sel_nx, pick;
   logic             any_req, start;

   bys_pick #(.N(N_REQ)) pick_i (.req_i(xreq_i), .pick_o(pick));

   assign any_req = |xreq_i;
   assign start   = (own_q == OWN_CORE) && !busy_q && !req_s_i && any_req;

   always_comb begin
      own_nx = own_q;
      unique case (own_q)
         OWN_CORE: if (req_s_i && (!busy_q || acc_done_i)) own_nx = OWN_EXT;
         OWN_EXT:  if (!req_s_i)                           own_nx = OWN_CORE;
         default:  own_nx = OWN_CORE;
      endcase
   end

   always_comb begin
      busy_nx = busy_q;
      sel_nx  = sel_q;
      if (start) begin
         busy_nx = 1'b1;
         sel_nx  = pick;
      end else if (busy_q && acc_done_i) begin
         busy_nx = 1'b0;
         sel_nx  = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q  <= OWN_CORE;
         busy_q <= 1'b0;
         sel_q  <= '0;
      end else begin
         own_q  <= own_nx;
         busy_q <= busy_nx;
         sel_q  <= sel_nx;
      end
   end

   assign grant_q_o  = (own_q == OWN_EXT);
   assign grant_nx_o = (own_nx == OWN_EXT);
   assign busy_o     = busy_q;
   assign sel_o      = sel_q;

   p_idle_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_q_o && !busy_q && req_s_i) |=> grant_q_o);
   p_defer_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_q_o && busy_q && !acc_done_i) |=> !grant_q_o);
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q_o && !req_s_i) |=> !grant_q_o);
   p_no_start_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_q_o && !busy_q) |=> !busy_q);
   p_sel_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ($countones(sel_q) == 1));
   p_sel_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (sel_q == '0));
endmodule

// File: rtl/bys_drive.sv
module bys_drive #(
   parameter bit GO_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic grant_nx_i,
   input  logic grant_i,
   input  logic go_mode_i,
   input  logic any_xreq_i,
   output logic drv_en_o,
   output logic halt_o,
   output logic hung_o
);
   logic go_eff;
   logic drv_en_q;

   generate
      if (GO_EN) begin : g_go
         assign go_eff = go_mode_i;
      end else begin : g_nogo
         assign go_eff = go_mode_i & 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) drv_en_q <= 1'b1;
      else        drv_en_q <= !grant_nx_i;
   end

   assign drv_en_o = drv_en_q;
   assign hung_o   = grant_i && any_xreq_i;
   assign halt_o   = grant_i && (!go_eff || any_xreq_i);

   p_drv_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en_o != grant_i);
   p_hung_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hung_o |-> (grant_i && halt_o));
endmodule

// File: rtl/ext_bus_yield_ctrl.sv
module ext_bus_yield_ctrl #(
   parameter int N_REQ       = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit GO_EN       = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             core_rst_i,
   input  logic             ext_req_i,
   input  logic             go_mode_i,
   input  logic [N_REQ-1:0] xreq_i,
   input  logic             acc_done_i,
   output logic             grant_o,
   output logic             hung_o,
   output logic             drv_en_o,
   output logic             halt_o,
   output logic             acc_busy_o,
   output logic [N_REQ-1:0] acc_sel_o
);
   generate
      if (N_REQ < 1) begin : g_bad_n
         $error("ext_bus_yield_ctrl: N_REQ must be at least 1");
      end
   endgenerate

   logic             req_s;
   logic             grant_q, grant_nx;
   logic [N_REQ-1:0] xreq_m;

   assign xreq_m = core_rst_i ? '0 : xreq_i;

   bys_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d_i(ext_req_i), .q_o(req_s));

   bys_owner #(.N_REQ(N_REQ)) owner_i (
      .clk(clk), .rst_n(rst_n), .req_s_i(req_s), .xreq_i(xreq_m),
      .acc_done_i(acc_done_i), .grant_q_o(grant_q), .grant_nx_o(grant_nx),
      .busy_o(acc_busy_o), .sel_o(acc_sel_o));

   bys_drive #(.GO_EN(GO_EN)) drive_i (
      .clk(clk), .rst_n(rst_n), .grant_nx_i(grant_nx), .grant_i(grant_q),
      .go_mode_i(go_mode_i), .any_xreq_i(|xreq_m),
      .drv_en_o(drv_en_o), .halt_o(halt_o), .hung_o(hung_o));

   assign grant_o = grant_q;

   p_core_rst_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (core_rst_i && !acc_busy_o) |=> !acc_busy_o);
endmodule

// File: tb/ext_bus_yield_ctrl_tb_top.sv
module ext_bus_yield_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       core_rst = 1'b0, ext_req = 1'b0, go_mode = 1'b0, done = 1'b0;
   logic [1:0] xreq = 2'b00;
   logic       grant, hung, drv_en, halt, busy;
   logic [1:0] sel;
   int         n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   ext_bus_yield_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .core_rst_i(core_rst), .ext_req_i(ext_req),
      .go_mode_i(go_mode), .xreq_i(xreq), .acc_done_i(done),
      .grant_o(grant), .hung_o(hung), .drv_en_o(drv_en), .halt_o(halt),
      .acc_busy_o(busy), .acc_sel_o(sel));

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
      end
      if (drv_en !== !grant) begin
         n_bad++;
         $display("FAIL R10 drv_en mirror: actual %0b expected %0b", drv_en, !grant);
      end
   endtask

   task automatic t_reset();
      chk("R11 grant", grant, 0);
      chk("R11 drv_en", drv_en, 1);
      chk("R11 halt/hung", {halt, hung}, 2'b00);
      chk("R11 busy", busy, 0);
      chk("R11 sel", sel, 2'b00);
   endtask

   task automatic t_idle_grant();
      ext_req = 1;
      tick(2);
      chk("R1 no grant before sync", grant, 0);
      tick(1);
      chk("R2 grant", grant, 1);
      chk("R2 halt", halt, 1);
      chk("R10 drv_en low", drv_en, 0);
      ext_req = 0;
      tick(2);
      chk("R6 still granted", grant, 1);
      tick(1);
      chk("R6 grant dropped", grant, 0);
      chk("R6 halt dropped", halt, 0);
   endtask

   task automatic t_inflight();
      xreq = 2'b01;
      tick(1);
      chk("R12 start sel", {busy, sel[0]}, 2'b11);
      ext_req = 1;
      tick(4);
      chk("R3 deferred", grant, 0);
      done = 1; xreq = 2'b00;
      tick(1);
      done = 0;
      chk("R3 grant after done", grant, 1);
      chk("R3 busy cleared", busy, 0);
      ext_req = 0;
      tick(3);
      chk("R6 released", grant, 0);
   endtask

   task automatic t_two_access();
      xreq = 2'b01;
      tick(1);
      ext_req = 1;
      tick(2);
      done = 1;
      tick(1);
      done = 0;
      chk("R4 granted between", {grant, busy}, 2'b10);
      chk("R7 hung while pending", hung, 1);
      tick(2);
      chk("R4 no second start", busy, 0);
      ext_req = 0;
      tick(3);
      chk("R8 grant/hung low", {grant, hung}, 2'b00);
      chk("R8 not yet started", busy, 0);
      tick(1);
      chk("R8 started after release", busy, 1);
      done = 1; xreq = 2'b00;
      tick(1);
      done = 0;
   endtask

   task automatic t_go_mode();
      go_mode = 1;
      ext_req = 1;
      tick(3);
      chk("R5 granted, running", {grant, halt}, 2'b10);
      chk("R7 no hung", hung, 0);
      xreq = 2'b10;
      #1;
      chk("R5 halt on need", halt, 1);
      chk("R7 hung for dma slot", hung, 1);
      ext_req = 0;
      tick(3);
      chk("R8 released", {grant, busy}, 2'b00);
      tick(1);
      chk("R12 dma served", {busy, sel}, 3'b110);
      done = 1; xreq = 2'b00;
      tick(1);
      done = 0;
      go_mode = 0;
   endtask

   task automatic t_priority();
      xreq = 2'b11;
      tick(1);
      chk("R12 low index first", sel, 2'b01);
      done = 1; xreq = 2'b10;
      tick(1);
      done = 0;
      chk("R12 idle sel zero", {busy, sel}, 3'b000);
      tick(1);
      chk("R12 next served", sel, 2'b10);
      done = 1; xreq = 2'b00;
      tick(1);
      done = 0;
   endtask

   task automatic t_core_reset();
      core_rst = 1;
      xreq = 2'b01;
      ext_req = 1;
      tick(3);
      chk("R9 grant in reset", grant, 1);
      chk("R9 no hung", hung, 0);
      ext_req = 0;
      tick(4);
      chk("R9 no start in reset", {grant, busy}, 2'b00);
      core_rst = 0;
      tick(1);
      chk("R9 start after reset", busy, 1);
      done = 1; xreq = 2'b00;
      tick(1);
      done = 0;
   endtask

   initial begin
      #400000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1;
      tick(1);
      t_reset();
      t_idle_grant();
      t_inflight();
      t_two_access();
      t_go_mode();
      t_priority();
      t_core_reset();
      tick(2);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule